// File: doc/BRIEF.md
# Transactional Buffer Conflict Tracker

This block sits beside a processor's first-level cache and tracks the memory lines touched by hardware transactions running on its local hardware contexts. Each buffer entry holds a line address, the architectural (pre-transaction) value, a speculative value, and one read bit and one write bit per context. A per-context state table records whether a context is idle, running a transaction, or aborted. An aborted context carries a sticky exception condition that turns its later accesses and commits into traps.

Conflicts are found in two ways. Coherence snoops from other processors are compared against the local read and write bits. Accesses by the local contexts are compared against each other's bits. Only one writer or any number of readers may hold a line at a time. The context that breaks this rule loses: a snooped local context, or the local context that makes the later access. An abort rolls back the speculative data. A commit makes that data architectural. A transaction that needs a new entry while every entry is held is aborted with an overflow cause, so that software can retry it by another path.

Commands arrive one per cycle on a single command port. Snoops arrive on their own port in the same cycle. An observation port reads the architectural value of any line held in the buffer.

Top module: `tbct_top`

## Requirements
- R1: A begin command (op code 1) from an idle or aborted context makes it active and clears its abort cause to 0 on the next cycle. A begin from an already active context is ignored.
- R2: A load (op 4) or store (op 5) from an active context sets that context's read or write bit on the line. A load returns the context's own speculative value if it has written the line, and the architectural value otherwise. Loads and stores from an idle context have no effect.
- R3: Lookup is fully associative over the entries. Load data appears with `ld_valid` on the cycle after the command. A miss takes the lowest-numbered entry that holds no read or write bits, and loads it with `cmd_fill`.
- R4: When a local access would break the single-writer rule, the accessing context is aborted with cause 2 (conflict) and its access is not performed. This covers a load of a line another local context has written, and a store to a line another local context has read or written. The other context is unaffected.
- R5: A snoop write to a line with a context's read or write bit set aborts that context with cause 2. A snoop read does the same only when the context's write bit is set.
- R6: Any abort sets the context's exception flag (`ctx_exc`) and pulses `abort_evt` for one cycle. It clears all of the context's read and write bits and restores the speculative value of every line it wrote to that line's architectural value. An explicit abort command (op 3) from an active context uses cause 1.
- R7: While a context's exception flag is set, its load, store or commit raises `trap` for one cycle with `trap_ctx` naming the context, and is not executed.
- R8: A commit (op 2) from an active context makes every line it wrote show its speculative value on the observation port. It also clears the context's bits and returns the context to idle.
- R9: An access that misses while no entry is free aborts the context with cause 3 (overflow).
- R10: When a snoop aborts a context in the same cycle that the context issues a command, the abort wins and the command is dropped.
- R11: After reset all contexts are idle, no abort, trap or load output is active, and the observation port reports no hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_ctx | input | CTX_W | Issuing context |
| cmd_op | input | 3 | 0 none, 1 begin, 2 commit, 3 abort, 4 load, 5 store |
| cmd_addr | input | ADDR_W | Line address of a load or store |
| cmd_wdata | input | DATA_W | Store data |
| cmd_fill | input | DATA_W | Current memory value of the line, used on allocation |
| snp_valid | input | 1 | Remote snoop present |
| snp_write | input | 1 | Snoop is for write ownership (1) or for reading (0) |
| snp_addr | input | ADDR_W | Snooped line address |
| obs_addr | input | ADDR_W | Line to observe |
| ld_valid | output | 1 | Load data valid |
| ld_data | output | DATA_W | Load data |
| trap | output | 1 | Access or commit from an aborted context |
| trap_ctx | output | CTX_W | Context that trapped |
| abort_evt | output | NUM_CTX | One-cycle abort pulse per context |
| abort_cause | output | NUM_CTX x 2 | Cause of each context's last abort |
| ctx_active | output | NUM_CTX | Context is running a transaction |
| ctx_exc | output | NUM_CTX | Context's exception flag |
| obs_hit | output | 1 | Observed line is held in the buffer |
| obs_data | output | DATA_W | Architectural value of the observed line |

## Verification
The bench builds the block with its defaults: eight entries, two contexts, 8-bit line addresses and 16-bit data. Random accesses are drawn from a pool of twelve addresses, so the pool is larger than the buffer. Overflow aborts, reuse of freed entries, and local conflicts between both contexts on shared lines therefore all occur often. Directed sequences add the exact cases of snoop read against a reader, snoop versus command in the same cycle, and the ninth distinct line.

// File: rtl/tbct_pkg.sv
// Shared encodings for the transactional buffer conflict tracker.
package tbct_pkg;

    typedef enum logic [2:0] {
        OP_NOP    = 3'd0,
        OP_BEGIN  = 3'd1,
        OP_COMMIT = 3'd2,
        OP_ABORT  = 3'd3,
        OP_LOAD   = 3'd4,
        OP_STORE  = 3'd5
    } tx_op_e;

    typedef enum logic [1:0] {
        CTX_IDLE    = 2'd0,
        CTX_ACTIVE  = 2'd1,
        CTX_ABORTED = 2'd2
    } ctx_st_e;

    typedef enum logic [1:0] {
        CAUSE_NONE     = 2'd0,
        CAUSE_EXPLICIT = 2'd1,
        CAUSE_CONFLICT = 2'd2,
        CAUSE_OVERFLOW = 2'd3
    } ab_cause_e;

endpackage

// File: rtl/tbct_pick.sv
// Lowest-index priority picker.
// Reports whether any request bit is set and the index of the lowest one.
// Assumes N >= 1; IW wide enough for N-1.
module tbct_pick #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);

    // scan from the top so the lowest set bit is written last
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                idx = IW'(i);
            end
        end
    end

endmodule

// File: rtl/tbct_ctx_table.sv
// Per-context transactional state table.
// Holds idle/active/aborted state and the last abort cause of each context.
// Abort has priority over begin, and begin over commit; the caller ensures
// that begin and commit are only raised in the legal source states.
module tbct_ctx_table #(
    parameter int NC = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NC-1:0]        begin_mask,
    input  logic [NC-1:0]        commit_mask,
    input  logic [NC-1:0]        abort_mask,
    input  logic [NC-1:0][1:0]   cause_in,
    output logic [NC-1:0][1:0]   st,
    output logic [NC-1:0][1:0]   cause
);
    import tbct_pkg::*;

    // state and cause update for every context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= '0;
            cause <= '0;
        end else begin
            for (int c = 0; c < NC; c++) begin
                if (abort_mask[c]) begin
                    st[c]    <= CTX_ABORTED;
                    cause[c] <= cause_in[c];
                end else if (begin_mask[c]) begin
                    st[c]    <= CTX_ACTIVE;
                    cause[c] <= CAUSE_NONE;
                end else if (commit_mask[c]) begin
                    st[c]    <= CTX_IDLE;
                end
            end
        end
    end

    for (genvar c = 0; c < NC; c++) begin : g_chk
        AST_BEGIN_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
            begin_mask[c] && !abort_mask[c] |=> st[c] == CTX_ACTIVE); // R1
        AST_EXC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            st[c] == CTX_ABORTED && !begin_mask[c] |=> st[c] == CTX_ABORTED); // R7
    end

endmodule

// File: rtl/tbct_line_store.sv
// Transactional line buffer storage.
// Each entry keeps address, architectural value, speculative value and
// per-context read/write bits. Rollback and commit act on every line the
// named contexts wrote; one access per cycle sets a bit and may allocate.
// Assumes the access context is never rolled back or committed in the same
// cycle, and that an allocated entry holds no bits.
module tbct_line_store #(
    parameter int N  = 8,
    parameter int NC = 2,
    parameter int AW = 8,
    parameter int DW = 16,
    parameter int IW = 3,
    parameter int CW = 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NC-1:0]         roll_mask,
    input  logic [NC-1:0]         cmt_mask,
    input  logic                  acc_en,
    input  logic                  acc_store,
    input  logic                  acc_alloc,
    input  logic [IW-1:0]         acc_idx,
    input  logic [CW-1:0]         acc_ctx,
    input  logic [AW-1:0]         acc_addr,
    input  logic [DW-1:0]         acc_fill,
    input  logic [DW-1:0]         acc_wdata,
    output logic [N-1:0]          ln_valid,
    output logic [N-1:0][AW-1:0]  ln_addr,
    output logic [N-1:0][DW-1:0]  ln_old,
    output logic [N-1:0][DW-1:0]  ln_new,
    output logic [N-1:0][NC-1:0]  ln_rd,
    output logic [N-1:0][NC-1:0]  ln_wr
);

    // entry update: rollback, commit, bit clearing, then the access
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ln_valid <= '0;
            ln_addr  <= '0;
            ln_old   <= '0;
            ln_new   <= '0;
            ln_rd    <= '0;
            ln_wr    <= '0;
        end else begin
            for (int e = 0; e < N; e++) begin
                for (int c = 0; c < NC; c++) begin
                    if (ln_wr[e][c] && roll_mask[c]) ln_new[e] <= ln_old[e];
                    if (ln_wr[e][c] && cmt_mask[c])  ln_old[e] <= ln_new[e];
                    if (roll_mask[c] || cmt_mask[c]) begin
                        ln_rd[e][c] <= 1'b0;
                        ln_wr[e][c] <= 1'b0;
                    end
                end
                if (acc_en && acc_idx == IW'(e)) begin
                    if (acc_alloc) begin
                        ln_valid[e] <= 1'b1;
                        ln_addr[e]  <= acc_addr;
                        ln_old[e]   <= acc_fill;
                        ln_new[e]   <= acc_store ? acc_wdata : acc_fill;
                    end else if (acc_store) begin
                        ln_new[e]   <= acc_wdata;
                    end
                    if (acc_store) ln_wr[e][acc_ctx] <= 1'b1;
                    else           ln_rd[e][acc_ctx] <= 1'b1;
                end
            end
        end
    end

    for (genvar e = 0; e < N; e++) begin : g_chk
        AST_ONE_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(ln_wr[e]) <= 1); // R4
    end

    AST_ALLOC_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        acc_en && acc_alloc |-> ln_rd[acc_idx] == '0 && ln_wr[acc_idx] == '0); // R3

endmodule

// File: rtl/tbct_top.sv
// Transactional buffer conflict tracker, top level.
// Decodes one command per cycle against the line buffer and the context
// table, matches remote snoops against the local read/write bits, and
// drives registered load, trap and abort outputs. Snoop aborts are taken
// first; a command from a context aborted by a snoop in the same cycle is
// dropped. Assumes cmd_ctx < NUM_CTX.
module tbct_top #(
    parameter int NUM_ENTRIES = 8,
    parameter int NUM_CTX     = 2,
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 16,
    localparam int CTX_W      = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cmd_valid,
    input  logic [CTX_W-1:0]         cmd_ctx,
    input  logic [2:0]               cmd_op,
    input  logic [ADDR_W-1:0]        cmd_addr,
    input  logic [DATA_W-1:0]        cmd_wdata,
    input  logic [DATA_W-1:0]        cmd_fill,
    input  logic                     snp_valid,
    input  logic                     snp_write,
    input  logic [ADDR_W-1:0]        snp_addr,
    input  logic [ADDR_W-1:0]        obs_addr,
    output logic                     ld_valid,
    output logic [DATA_W-1:0]        ld_data,
    output logic                     trap,
    output logic [CTX_W-1:0]         trap_ctx,
    output logic [NUM_CTX-1:0]       abort_evt,
    output logic [NUM_CTX-1:0][1:0]  abort_cause,
    output logic [NUM_CTX-1:0]       ctx_active,
    output logic [NUM_CTX-1:0]       ctx_exc,
    output logic                     obs_hit,
    output logic [DATA_W-1:0]        obs_data
);
    import tbct_pkg::*;

    localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;

    logic [NUM_ENTRIES-1:0]              ln_valid;
    logic [NUM_ENTRIES-1:0][ADDR_W-1:0]  ln_addr;
    logic [NUM_ENTRIES-1:0][DATA_W-1:0]  ln_old;
    logic [NUM_ENTRIES-1:0][DATA_W-1:0]  ln_new;
    logic [NUM_ENTRIES-1:0][NUM_CTX-1:0] ln_rd;
    logic [NUM_ENTRIES-1:0][NUM_CTX-1:0] ln_wr;
    logic [NUM_CTX-1:0][1:0]             ctx_state;

    logic [NUM_ENTRIES-1:0] busy, c_match, s_match, o_match;
    logic c_hit, s_hit, o_hit, f_any;
    logic [IDX_W-1:0] c_idx, s_idx, o_idx, f_idx;

    // per-entry match vectors for the three lookups and the free search
    for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_match
        assign busy[e]    = |{ln_rd[e], ln_wr[e]};
        assign c_match[e] = ln_valid[e] && ln_addr[e] == cmd_addr;
        assign s_match[e] = ln_valid[e] && ln_addr[e] == snp_addr;
        assign o_match[e] = ln_valid[e] && ln_addr[e] == obs_addr;
    end

    tbct_pick #(.N(NUM_ENTRIES), .IW(IDX_W)) u_pick_cmd (.req(c_match), .any(c_hit), .idx(c_idx));
    tbct_pick #(.N(NUM_ENTRIES), .IW(IDX_W)) u_pick_snp (.req(s_match), .any(s_hit), .idx(s_idx));
    tbct_pick #(.N(NUM_ENTRIES), .IW(IDX_W)) u_pick_obs (.req(o_match), .any(o_hit), .idx(o_idx));
    tbct_pick #(.N(NUM_ENTRIES), .IW(IDX_W)) u_pick_free (.req(~busy), .any(f_any), .idx(f_idx));

    // snoop conflicts: remote write vs any local bit, remote read vs local write
    logic [NUM_CTX-1:0] snp_ab;
    always_comb begin
        for (int c = 0; c < NUM_CTX; c++) begin
            snp_ab[c] = snp_valid && s_hit && ctx_state[c] == CTX_ACTIVE &&
                        (ln_wr[s_idx][c] || (snp_write && ln_rd[s_idx][c]));
        end
    end

    tx_op_e              op;
    logic                cmd_live, is_store, other_rd, other_wr;
    logic [1:0]          k_st;
    logic [NUM_CTX-1:0]  own;

    assign op       = tx_op_e'(cmd_op);
    assign cmd_live = cmd_valid && !snp_ab[cmd_ctx];
    assign k_st     = ctx_state[cmd_ctx];
    assign is_store = (op == OP_STORE);
    assign own      = NUM_CTX'(1) << cmd_ctx;
    assign other_rd = |(ln_rd[c_idx] & ~own);
    assign other_wr = |(ln_wr[c_idx] & ~own);

    logic [NUM_CTX-1:0] begin_mask, cmt_mask, cmd_ab, abort_mask;
    logic [1:0]         cmd_cause;
    logic               acc_en, acc_alloc, trap_d, ld_valid_d;
    logic [IDX_W-1:0]   acc_idx;
    logic [DATA_W-1:0]  ld_data_d;

    // command decode against the issuing context's state
    always_comb begin
        begin_mask = '0;
        cmt_mask   = '0;
        cmd_ab     = '0;
        cmd_cause  = CAUSE_NONE;
        acc_en     = 1'b0;
        acc_alloc  = 1'b0;
        acc_idx    = c_idx;
        trap_d     = 1'b0;
        ld_valid_d = 1'b0;
        ld_data_d  = c_hit ? (ln_wr[c_idx][cmd_ctx] ? ln_new[c_idx] : ln_old[c_idx]) : cmd_fill;
        if (cmd_live) begin
            case (op)
                OP_BEGIN: if (k_st != CTX_ACTIVE) begin_mask[cmd_ctx] = 1'b1;
                OP_COMMIT: begin
                    if (k_st == CTX_ACTIVE)       cmt_mask[cmd_ctx] = 1'b1;
                    else if (k_st == CTX_ABORTED) trap_d = 1'b1;
                end
                OP_ABORT: begin
                    if (k_st == CTX_ACTIVE) begin
                        cmd_ab[cmd_ctx] = 1'b1;
                        cmd_cause       = CAUSE_EXPLICIT;
                    end
                end
                OP_LOAD, OP_STORE: begin
                    if (k_st == CTX_ABORTED) begin
                        trap_d = 1'b1;
                    end else if (k_st == CTX_ACTIVE) begin
                        if (c_hit) begin
                            if (other_wr || (is_store && other_rd)) begin
                                cmd_ab[cmd_ctx] = 1'b1;
                                cmd_cause       = CAUSE_CONFLICT;
                            end else begin
                                acc_en     = 1'b1;
                                ld_valid_d = !is_store;
                            end
                        end else if (f_any) begin
                            acc_en     = 1'b1;
                            acc_alloc  = 1'b1;
                            acc_idx    = f_idx;
                            ld_valid_d = !is_store;
                        end else begin
                            cmd_ab[cmd_ctx] = 1'b1;
                            cmd_cause       = CAUSE_OVERFLOW;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    logic [NUM_CTX-1:0][1:0] cause_in;
    assign abort_mask = snp_ab | cmd_ab;

    // per-context cause: command-made abort carries its own cause, else snoop
    always_comb begin
        for (int c = 0; c < NUM_CTX; c++) begin
            cause_in[c] = cmd_ab[c] ? cmd_cause : CAUSE_CONFLICT;
        end
    end

    tbct_ctx_table #(.NC(NUM_CTX)) u_ctx (
        .clk         (clk),
        .rst_n       (rst_n),
        .begin_mask  (begin_mask),
        .commit_mask (cmt_mask),
        .abort_mask  (abort_mask),
        .cause_in    (cause_in),
        .st          (ctx_state),
        .cause       (abort_cause)
    );

    tbct_line_store #(
        .N(NUM_ENTRIES), .NC(NUM_CTX), .AW(ADDR_W), .DW(DATA_W), .IW(IDX_W), .CW(CTX_W)
    ) u_lines (
        .clk       (clk),
        .rst_n     (rst_n),
        .roll_mask (abort_mask),
        .cmt_mask  (cmt_mask),
        .acc_en    (acc_en),
        .acc_store (is_store),
        .acc_alloc (acc_alloc),
        .acc_idx   (acc_idx),
        .acc_ctx   (cmd_ctx),
        .acc_addr  (cmd_addr),
        .acc_fill  (cmd_fill),
        .acc_wdata (cmd_wdata),
        .ln_valid  (ln_valid),
        .ln_addr   (ln_addr),
        .ln_old    (ln_old),
        .ln_new    (ln_new),
        .ln_rd     (ln_rd),
        .ln_wr     (ln_wr)
    );

    // registered event outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_valid  <= 1'b0;
            ld_data   <= '0;
            trap      <= 1'b0;
            trap_ctx  <= '0;
            abort_evt <= '0;
        end else begin
            ld_valid  <= ld_valid_d;
            ld_data   <= ld_data_d;
            trap      <= trap_d;
            trap_ctx  <= cmd_ctx;
            abort_evt <= abort_mask;
        end
    end

    // context status and observation port
    always_comb begin
        for (int c = 0; c < NUM_CTX; c++) begin
            ctx_active[c] = ctx_state[c] == CTX_ACTIVE;
            ctx_exc[c]    = ctx_state[c] == CTX_ABORTED;
        end
    end
    assign obs_hit  = o_hit;
    assign obs_data = ln_old[o_idx];

    // column summary of held bits per context, for the checks below
    logic [NUM_CTX-1:0] col_bits;
    always_comb begin
        col_bits = '0;
        for (int e = 0; e < NUM_ENTRIES; e++) col_bits = col_bits | ln_rd[e] | ln_wr[e];
    end

    for (genvar c = 0; c < NUM_CTX; c++) begin : g_chk
        AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            abort_evt[c] |-> !col_bits[c]); // R6
        AST_IDLE_NO_BITS: assert property (@(posedge clk) disable iff (!rst_n)
            !ctx_active[c] |-> !col_bits[c]); // R2
        AST_OVF_FULL: assert property (@(posedge clk) disable iff (!rst_n)
            abort_evt[c] && abort_cause[c] == CAUSE_OVERFLOW |-> $past(&busy)); // R9
    end

    AST_TRAP_EXC: assert property (@(posedge clk) disable iff (!rst_n)
        trap |-> $past(ctx_state[cmd_ctx]) == CTX_ABORTED); // R7

endmodule

// File: tb/sim_tbct_top.sv
module sim_tbct_top;
    localparam int CLK_PERIOD = 10;
    localparam int NE = 8;
    localparam int NC = 2;
    localparam int AW = 8;
    localparam int DW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic [0:0] cmd_ctx = '0;
    logic [2:0] cmd_op = '0;
    logic [AW-1:0] cmd_addr = '0;
    logic [DW-1:0] cmd_wdata = '0, cmd_fill = '0;
    logic snp_valid = 1'b0, snp_write = 1'b0;
    logic [AW-1:0] snp_addr = '0, obs_addr = '0;
    logic ld_valid, trap, obs_hit;
    logic [DW-1:0] ld_data, obs_data;
    logic [0:0] trap_ctx;
    logic [NC-1:0] abort_evt, ctx_active, ctx_exc;
    logic [NC-1:0][1:0] abort_cause;

    tbct_top #(.NUM_ENTRIES(NE), .NUM_CTX(NC), .ADDR_W(AW), .DATA_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ctx(cmd_ctx), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_fill(cmd_fill),
        .snp_valid(snp_valid), .snp_write(snp_write), .snp_addr(snp_addr), .obs_addr(obs_addr),
        .ld_valid(ld_valid), .ld_data(ld_data), .trap(trap), .trap_ctx(trap_ctx),
        .abort_evt(abort_evt), .abort_cause(abort_cause), .ctx_active(ctx_active),
        .ctx_exc(ctx_exc), .obs_hit(obs_hit), .obs_data(obs_data)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;

    // reference model state
    bit            m_val [NE];
    logic [AW-1:0] m_addr[NE];
    logic [DW-1:0] m_old [NE];
    logic [DW-1:0] m_new [NE];
    bit            m_rd  [NE][NC];
    bit            m_wr  [NE][NC];
    int            m_st  [NC];
    int            m_cause[NC];
    bit            e_ldv, e_trap;
    logic [DW-1:0] e_ldd;
    int            e_tctx;
    bit            e_ab  [NC];

    task automatic chk(input string r, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", r, what, act, exp, $time);
        end
    endtask

    function automatic int m_find(input logic [AW-1:0] a);
        for (int e = 0; e < NE; e++) if (m_val[e] && m_addr[e] == a) return e;
        return -1;
    endfunction

    function automatic int m_free();
        for (int e = 0; e < NE; e++) begin
            bit any = 0;
            for (int c = 0; c < NC; c++) any |= m_rd[e][c] | m_wr[e][c];
            if (!any) return e;
        end
        return -1;
    endfunction

    // expected behaviour of one cycle, from the requirements
    task automatic m_step(input int op, input int k, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                          input logic [DW-1:0] fl, input bit sv, input bit sw, input logic [AW-1:0] sa);
        int h, f;
        bit oth;
        e_ldv = 0; e_trap = 0; e_tctx = k;
        for (int c = 0; c < NC; c++) e_ab[c] = 0;
        if (sv) begin
            h = m_find(sa);
            if (h >= 0)
                for (int c = 0; c < NC; c++)
                    if (m_st[c] == 1 && (m_wr[h][c] || (sw && m_rd[h][c]))) begin
                        e_ab[c] = 1; m_cause[c] = 2;
                    end
        end
        if (!e_ab[k]) begin
            case (op)
                1: if (m_st[k] != 1) begin m_st[k] = 1; m_cause[k] = 0; end
                2: if (m_st[k] == 1) begin
                       for (int e = 0; e < NE; e++) begin
                           if (m_wr[e][k]) m_old[e] = m_new[e];
                           m_rd[e][k] = 0; m_wr[e][k] = 0;
                       end
                       m_st[k] = 0;
                   end else if (m_st[k] == 2) e_trap = 1;
                3: if (m_st[k] == 1) begin e_ab[k] = 1; m_cause[k] = 1; end
                4, 5: if (m_st[k] == 2) e_trap = 1;
                      else if (m_st[k] == 1) begin
                          h = m_find(a);
                          if (h >= 0) begin
                              oth = 0;
                              for (int c = 0; c < NC; c++)
                                  if (c != k && (m_wr[h][c] || (op == 5 && m_rd[h][c]))) oth = 1;
                              if (oth) begin e_ab[k] = 1; m_cause[k] = 2; end
                              else if (op == 4) begin
                                  m_rd[h][k] = 1; e_ldv = 1;
                                  e_ldd = m_wr[h][k] ? m_new[h] : m_old[h];
                              end else begin
                                  m_wr[h][k] = 1; m_new[h] = wd;
                              end
                          end else begin
                              f = m_free();
                              if (f < 0) begin e_ab[k] = 1; m_cause[k] = 3; end
                              else begin
                                  m_val[f] = 1; m_addr[f] = a; m_old[f] = fl;
                                  m_new[f] = (op == 5) ? wd : fl;
                                  if (op == 5) m_wr[f][k] = 1;
                                  else begin m_rd[f][k] = 1; e_ldv = 1; e_ldd = fl; end
                              end
                          end
                      end
                default: ;
            endcase
        end
        for (int c = 0; c < NC; c++)
            if (e_ab[c]) begin
                m_st[c] = 2;
                for (int e = 0; e < NE; e++) begin
                    if (m_wr[e][c]) m_new[e] = m_old[e];
                    m_rd[e][c] = 0; m_wr[e][c] = 0;
                end
            end
    endtask

    // drive one cycle at the falling edge, compare after the next rising edge
    task automatic step(input int op, input int k, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                        input logic [DW-1:0] fl, input bit sv, input bit sw, input logic [AW-1:0] sa,
                        input logic [AW-1:0] oa);
        int h;
        cmd_valid = (op != 0); cmd_op = 3'(op); cmd_ctx = 1'(k);
        cmd_addr = a; cmd_wdata = wd; cmd_fill = fl;
        snp_valid = sv; snp_write = sw; snp_addr = sa; obs_addr = oa;
        m_step(op, k, a, wd, fl, sv, sw, sa);
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 0; snp_valid = 0;
        chk("R3", "ld_valid", 32'(ld_valid), 32'(e_ldv));
        if (e_ldv) chk("R2", "ld_data", 32'(ld_data), 32'(e_ldd));
        chk("R7", "trap", 32'(trap), 32'(e_trap));
        if (e_trap) chk("R7", "trap_ctx", 32'(trap_ctx), 32'(e_tctx));
        for (int c = 0; c < NC; c++) begin
            chk("R6", "abort_evt", 32'(abort_evt[c]), 32'(e_ab[c]));
            chk("R4", "abort_cause", 32'(abort_cause[c]), 32'(m_cause[c]));
            chk("R1", "ctx_active", 32'(ctx_active[c]), 32'(m_st[c] == 1));
            chk("R6", "ctx_exc", 32'(ctx_exc[c]), 32'(m_st[c] == 2));
        end
        h = m_find(oa);
        chk("R8", "obs_hit", 32'(obs_hit), 32'(h >= 0));
        if (h >= 0) chk("R8", "obs_data", 32'(obs_data), 32'(m_old[h]));
    endtask

    task automatic cmd(input int op, input int k, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                       input logic [DW-1:0] fl);
        step(op, k, a, wd, fl, 0, 0, '0, a);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog R11 actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20061204));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R11: reset state
        chk("R11", "ctx_active", 32'(ctx_active), 0);
        chk("R11", "ctx_exc", 32'(ctx_exc), 0);
        chk("R11", "abort_evt", 32'(abort_evt), 0);
        chk("R11", "trap", 32'(trap), 0);
        chk("R11", "ld_valid", 32'(ld_valid), 0);
        chk("R11", "obs_hit", 32'(obs_hit), 0);

        // R1, R2: own write then own read returns speculative value
        cmd(1, 0, 0, 0, 0);
        cmd(1, 1, 0, 0, 0);
        cmd(5, 0, 8'h10, 16'hAAAA, 16'h1111);
        cmd(4, 0, 8'h10, 0, 16'h1111);
        chk("R2", "own spec read", 32'(ld_data), 32'hAAAA);
        chk("R2", "arch value", 32'(obs_data), 32'h1111);
        // R4: later local reader of a written line loses
        cmd(4, 1, 8'h10, 0, 0);
        chk("R4", "local conflict cause", 32'(abort_cause[1]), 2);
        chk("R4", "winner still active", 32'(ctx_active[0]), 1);
        // R7: traps while aborted
        cmd(4, 1, 8'h10, 0, 0);
        chk("R7", "trap on load", 32'(trap), 1);
        cmd(2, 1, 0, 0, 0);
        chk("R7", "trap on commit", 32'(trap), 1);
        // R8: commit publishes
        cmd(2, 0, 8'h10, 0, 0);
        chk("R8", "committed value", 32'(obs_data), 32'hAAAA);
        // R2: idle context access ignored
        cmd(4, 0, 8'h10, 0, 0);
        chk("R2", "idle load ignored", 32'(ld_valid), 0);
        // R5: snoop read against a writer
        cmd(1, 1, 0, 0, 0);
        cmd(1, 0, 0, 0, 0);
        cmd(5, 0, 8'h20, 16'h2222, 16'h0202);
        step(0, 0, 0, 0, 0, 1, 0, 8'h20, 8'h20);
        chk("R5", "snoop read vs writer", 32'(abort_cause[0]), 2);
        chk("R6", "rollback", 32'(obs_data), 32'h0202);
        // R5: snoop read vs reader is harmless, snoop write is not
        cmd(1, 0, 0, 0, 0);
        cmd(4, 0, 8'h30, 0, 16'h0303);
        step(0, 0, 0, 0, 0, 1, 0, 8'h30, 8'h30);
        chk("R5", "snoop read vs reader", 32'(abort_evt[0]), 0);
        step(0, 0, 0, 0, 0, 1, 1, 8'h30, 8'h30);
        chk("R5", "snoop write vs reader", 32'(abort_evt[0]), 1);
        // R6: explicit abort
        cmd(1, 0, 0, 0, 0);
        cmd(5, 0, 8'h40, 16'h4444, 16'h0404);
        cmd(3, 0, 8'h40, 0, 0);
        chk("R6", "explicit cause", 32'(abort_cause[0]), 1);
        chk("R6", "explicit rollback", 32'(obs_data), 32'h0404);
        // R9: ninth distinct line overflows
        cmd(1, 0, 0, 0, 0);
        for (int i = 0; i < 9; i++) cmd(4, 0, 8'h50 + 8'(i), 0, 16'(i));
        chk("R9", "overflow cause", 32'(abort_cause[0]), 3);
        // R10: snoop abort beats same-cycle command
        cmd(1, 0, 0, 0, 0);
        cmd(5, 0, 8'h60, 16'h6666, 0);
        step(4, 0, 8'h61, 0, 16'h6161, 1, 1, 8'h60, 8'h61);
        chk("R10", "load dropped", 32'(ld_valid), 0);
        chk("R10", "aborted", 32'(abort_evt[0]), 1);
        chk("R10", "no allocation", 32'(obs_hit), 0);

        // constrained random mix
        for (int n = 0; n < 4000; n++) begin
            int r, op;
            r = $urandom % 100;
            op = (r < 5) ? 0 : (r < 20) ? 1 : (r < 30) ? 2 : (r < 35) ? 3 : (r < 68) ? 4 : 5;
            step(op, $urandom % 2, 8'h80 + 8'($urandom % 12), 16'($urandom), 16'($urandom),
                 ($urandom % 5) == 0, $urandom % 2, 8'h80 + 8'($urandom % 12),
                 8'h80 + 8'($urandom % 12));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule